// File: doc/BRIEF.md
# External Pin Interrupt Sense Unit

This block conditions eight asynchronous external interrupt pins and turns each into a clean, active-high, level request toward a parent interrupt controller. Every pin is first brought into the clock domain through a two-stage synchroniser. A per-pin detector then applies the trigger mode selected in software: low level, falling edge, rising edge or both edges. A detected event sets a sticky pending flag, and that flag drives the pin's request output directly.

Software reaches the block through a 32-bit register port with a single-cycle request strobe. Read data is combinational and valid in the strobe cycle. There are two mapped words. The pending word is cleared by writing zero to a bit; bits written as one are left alone. The mode word holds one 2-bit selector per pin. Because a level-triggered pin re-asserts its flag while it stays low, a handler has to release the pin before a clear takes effect.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, the pending word and the mode word both read zero and every request output is low. This selects low-level mode on all pins with nothing pending.
- R2: The pending word is at byte offset 0x10, with pin n's flag in bit n. The mode word is at byte offset 0x14, with pin n's selector in bits [2n+1:2n]. Mode bits written are read back unchanged, and bits 31:16 of the mode word and bits 31:8 of the pending word read as zero.
- R3: Mode selector 0 (low level) sets pin n's flag while the synchronised pin is low. A pin change reaches the flag on the third rising clock edge after it is driven.
- R4: Selector 1 (falling edge) sets the flag only on a high-to-low change of the synchronised pin. A held level or a rising change sets nothing.
- R5: Selector 2 (rising edge) sets the flag only on a low-to-high change of the synchronised pin.
- R6: Selector 3 (both edges) sets the flag on any change of the synchronised pin.
- R7: Writing the pending word clears each flag whose write bit is 0 and leaves each flag whose write bit is 1 unchanged.
- R8: In low-level mode, a clear written while the pin is still low has no lasting effect: the flag is 1 again in the cycle after the write.
- R9: If an event for pin n is detected in the same cycle as a write that clears flag n, the flag stays 1.
- R10: Request output n is high exactly when flag n is set, whatever trigger mode is selected.
- R11: A read at any offset other than 0x10 and 0x14 returns zero. A write to any such offset changes neither mapped word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Asynchronous external interrupt pins |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while a read strobe is high |
| irq_o | output | 8 | Active-high per-pin request toward the parent controller |

## Verification
The bench sweeps every trigger selector on every pin, with both a falling and a rising pin change, while the other pins sit in a quiet mode. It computes the expected flag from the selector and the two pin levels. A design that decoded a selector wrongly, or let one pin's field control another pin, would show a wrong or misplaced flag. The bench places a clear write on the exact cycle a new rising edge is detected; a design that let the clear win would drop a real interrupt. It also clears a low-level pin while the pin is still held low, and checks that the flag and output are still high. A partial clear confirms that bits written as one are kept. Unmapped reads and writes are checked against both mapped words, so a decoder that aliased offsets would corrupt them.

// File: rtl/eis_pkg.sv
`timescale 1ns/1ps
package eis_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_BOTH = 2'd3
  } trig_e;
endpackage

// File: rtl/eis_sync.sv
`timescale 1ns/1ps
module eis_sync #(
  parameter int unsigned N      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] stage_q [STAGES];

  // reset to idle-high so a released pin shows no edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '1;
    else         stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '1;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/eis_detect.sv
`timescale 1ns/1ps
module eis_detect
  import eis_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   level_i,
  input  logic [2*N-1:0] mode_i,
  output logic [N-1:0]   evt_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= level_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_pin
    trig_e mode;
    logic  fall, rise;
    assign mode = trig_e'(mode_i[2*g +: 2]);
    assign fall = prev_q[g] & ~level_i[g];
    assign rise = ~prev_q[g] & level_i[g];
    always_comb begin
      unique case (mode)
        TRIG_LOW:  evt_o[g] = ~level_i[g];
        TRIG_FALL: evt_o[g] = fall;
        TRIG_RISE: evt_o[g] = rise;
        default:   evt_o[g] = fall | rise;
      endcase
    end
  end
endmodule

// File: rtl/eis_regs.sv
`timescale 1ns/1ps
module eis_regs #(
  parameter int unsigned N        = 8,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h10,
  parameter logic [ADDR_W-1:0] MODE_OFS = 'h14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      evt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N-1:0]      status_o,
  output logic [2*N-1:0]    mode_o
);
  localparam int unsigned MW = 2 * N;

  logic [N-1:0]  status_q, status_d;
  logic [MW-1:0] mode_q;
  logic          stat_wr, mode_wr, rd;

  assign rd      = req_i & ~we_i;
  assign stat_wr = req_i & we_i & (addr_i == STAT_OFS);
  assign mode_wr = req_i & we_i & (addr_i == MODE_OFS);

  // new events override a clear in the same cycle
  always_comb begin
    status_d = status_q;
    if (stat_wr) status_d = status_q & wdata_i[N-1:0];
    status_d = status_d | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mode_q   <= '0;
    end else begin
      status_q <= status_d;
      if (mode_wr) mode_q <= wdata_i[MW-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd && addr_i == STAT_OFS)      rdata_o[N-1:0]  = status_q;
    else if (rd && addr_i == MODE_OFS) rdata_o[MW-1:0] = mode_q;
  end

  assign status_o = status_q;
  assign mode_o   = mode_q;

  AST_SET_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & ~$past(status_q) & ~$past(evt_i)) == '0)); // R3
  AST_CLR_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(status_q) & ~status_q) != '0) |-> $past(stat_wr)); // R7
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R9
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_wr |=> $stable(mode_q)); // R11
endmodule

// File: rtl/ext_irq_sense.sv
`timescale 1ns/1ps
module ext_irq_sense #(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [NUM_PINS-1:0] irq_o
);
  localparam int unsigned MW = 2 * NUM_PINS;

  logic [NUM_PINS-1:0] pin_sync, evt, status;
  logic [MW-1:0]       mode;
  logic [NUM_PINS-1:0] low_held;

  eis_sync #(.N(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(pin_i), .sync_o(pin_sync)
  );

  eis_detect #(.N(NUM_PINS)) u_detect (
    .clk_i, .rst_ni, .level_i(pin_sync), .mode_i(mode), .evt_o(evt)
  );

  eis_regs #(.N(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .evt_i(evt), .rdata_o, .status_o(status), .mode_o(mode)
  );

  assign irq_o = status;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_low
    assign low_held[g] = ~pin_sync[g] & (mode[2*g +: 2] == 2'd0);
  end

  AST_LEVEL_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irq_o & $past(low_held)) == $past(low_held))); // R8
endmodule

// File: tb/sim_ext_irq_sense.sv
`timescale 1ns/1ps
module sim_ext_irq_sense;
  localparam logic [7:0] A_STAT = 8'h10;
  localparam logic [7:0] A_MODE = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin = 8'hFF;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0]  irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ext_irq_sense u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic expect_flag(int m, logic o, logic n);
    case (m)
      0: return ~o | ~n;       // sticky from low before or after the change
      1: return o & ~n;
      2: return ~o & n;
      default: return o ^ n;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_sim();
  end

  initial begin
    logic [31:0] d, mval;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    rd(A_STAT, d); check("R1 status", d, 0);
    rd(A_MODE, d); check("R1 mode", d, 0);
    check("R1 irq", {24'd0, irq}, 0);
    idle(4);
    check("R1 idle pins", {24'd0, irq}, 0);

    wr(A_MODE, 32'hFFFF_1B6C);
    rd(A_MODE, d); check("R2 mode readback", d, 32'h0000_1B6C);

    // sweep: every selector on every pin, both transitions
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 8; p++) begin
        for (int t = 0; t < 2; t++) begin
          logic o, n;
          o = (t == 0);
          n = ~o;
          mval = (32'hAAAA & ~(32'h3 << (2*p))) | (32'(m) << (2*p));
          wr(A_MODE, mval);
          if (t == 0) begin
            rd(A_MODE, d); check("R2 mode field", d, mval);
          end
          pin = 8'hFF; pin[p] = o;
          idle(5);
          wr(A_STAT, 32'h0);
          idle(1);
          pin[p] = n;
          idle(4);
          rd(A_STAT, d);
          case (m)
            0: check("R3 low level", d, 32'(expect_flag(m, o, n)) << p);
            1: check("R4 falling", d, 32'(expect_flag(m, o, n)) << p);
            2: check("R5 rising", d, 32'(expect_flag(m, o, n)) << p);
            default: check("R6 both", d, 32'(expect_flag(m, o, n)) << p);
          endcase
          check("R10 irq", {24'd0, irq}, 32'(expect_flag(m, o, n)) << p);
        end
      end
    end

    // R3 latency: flag appears at the third rising edge
    wr(A_MODE, 32'hAAAA);
    pin = 8'hFF; idle(5); wr(A_STAT, 0); idle(1);
    pin[4] = 1'b0; wr(A_MODE, 32'hAAA8 & ~32'h300);
    pin = 8'hFF; idle(5); wr(A_STAT, 0); idle(1);
    pin[4] = 1'b0;
    idle(1); check("R3 latency edge 1", {24'd0, irq}, 0);
    idle(1); check("R3 latency edge 2", {24'd0, irq}, 0);
    idle(1); check("R3 latency edge 3", {24'd0, irq}, 32'h10);
    pin = 8'hFF;

    // R7 partial clear
    wr(A_MODE, 32'hAAAA);
    pin = 8'h00; idle(5); wr(A_STAT, 0); idle(1);
    pin = 8'h0F; idle(5);
    rd(A_STAT, d); check("R7 four set", d, 32'h0F);
    wr(A_STAT, 32'h05); idle(1);
    rd(A_STAT, d); check("R7 keep ones", d, 32'h05);
    wr(A_STAT, 32'hFF); idle(1);
    rd(A_STAT, d); check("R7 all ones no change", d, 32'h05);
    wr(A_STAT, 32'hFB); idle(1);
    rd(A_STAT, d); check("R7 clear bit2", d, 32'h01);

    // R8 clear while low-level pin held low
    wr(A_MODE, 32'hAAA8);
    pin = 8'hFE; idle(5);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); check("R8 reasserted", d, 32'h01);
    check("R8 irq", {24'd0, irq}, 32'h01);
    pin = 8'hFF; idle(5);
    wr(A_STAT, 32'h0); idle(1);
    rd(A_STAT, d); check("R8 released clears", d, 0);

    // R9 clear coincides with a new rising edge on pin 6
    wr(A_MODE, 32'hAAAA);
    pin = 8'hBF; idle(5); wr(A_STAT, 0); idle(1);
    pin = 8'hFF; idle(5);
    pin = 8'hBF; idle(5);
    rd(A_STAT, d); check("R9 setup", d, 32'h40);
    pin = 8'hFF;
    @(negedge clk); @(negedge clk);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); check("R9 set wins", d, 32'h40);
    wr(A_STAT, 32'h0); idle(1);
    rd(A_STAT, d); check("R9 plain clear", d, 0);

    // R11 unmapped offsets
    wr(A_MODE, 32'h5A5A);
    pin = 8'h00; idle(5); wr(A_STAT, 32'hFF);
    rd(A_STAT, d);
    mval = d;
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0);
    wr(8'h11, 32'h0);
    wr(8'h15, 32'h0);
    rd(A_MODE, d); check("R11 mode untouched", d, 32'h5A5A);
    rd(A_STAT, d); check("R11 status untouched", d, mval);
    rd(8'h18, d); check("R11 read 0x18", d, 0);
    rd(8'h11, d); check("R11 read 0x11", d, 0);
    rd(8'h00, d); check("R11 read 0x00", d, 0);
    check("R2 status upper zero", mval & 32'hFFFF_FF00, 0);

    finish_sim();
  end
endmodule